// File: doc/BRIEF.md
# Flash Ready Status Poller

This block decides when a parallel NOR flash device has finished an internal program or erase cycle. It does no bus timing itself. It asks an external bus port for reads of the status location through a request/valid handshake, and it watches the returned byte. It then reports either completion or that it has given up.

Two detection methods are offered, and a mode input picks one at start. In toggle-bit mode, the device flips bit 6 on every read while it is busy. The block takes one reference read and then compares bit 6 of each new read with the previous one. In data-polling mode, bit 7 of every read is compared against bit 7 of the byte that was written. A parameter bounds the number of comparing reads. When that bound is reached without a match, a timeout pulse is raised instead of a done pulse.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `rd_req_o`, `done_o` and `timeout_o` are all low.
- R2: A `start_i` pulse while idle raises `rd_req_o` on the next cycle. It also captures `mode_i` (0 = toggle-bit, 1 = data-polling) and `expect_i`.
- R3: Once raised, `rd_req_o` stays high until a cycle in which `rd_valid_i` is high. A read is accepted in that cycle, with `rd_data_i` sampled.
- R4: In toggle-bit mode the first accepted read only sets the reference. It never completes the operation and does not count toward the limit.
- R5: In toggle-bit mode a read whose bit 6 equals bit 6 of the previous read completes the operation. Bits other than bit 6 have no effect.
- R6: In toggle-bit mode a read whose bit 6 differs from the reference becomes the new reference and counts as one failed attempt.
- R7: In data-polling mode a read whose bit 7 equals bit 7 of the captured expected byte completes the operation. Any other read counts as one failed attempt. Bits 6..0 of both bytes have no effect.
- R8: When the number of failed attempts reaches `MAX_TRIES` (default 0x0FFFFFFF), `timeout_o` pulses instead of `done_o`.
- R9: `done_o` and `timeout_o` are single-cycle pulses, never high together, and are raised the cycle after the deciding read is accepted. During the pulse `rd_req_o` is low, and the block is idle.
- R10: A `start_i` pulse while polling is ignored. The captured mode and expected byte are kept, and the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a polling run (honoured only when idle) |
| mode_i | input | 1 | 0 = toggle-bit, 1 = data-polling |
| expect_i | input | 8 | Byte that was programmed; bit 7 is used in data-polling mode |
| rd_req_o | output | 1 | Read request toward the bus port |
| rd_valid_i | input | 1 | Bus port returns read data this cycle |
| rd_data_i | input | 8 | Byte read from the flash |
| done_o | output | 1 | One-cycle pulse: operation finished |
| timeout_o | output | 1 | One-cycle pulse: attempt limit reached |

## Verification
The assertions assume the bus port raises `rd_valid_i` only while `rd_req_o` is high, for one cycle per read. They also assume that `start_i` is a synchronous pulse. The stimulus meets this with a bus model that answers each request at most once and then drops valid for a cycle, with optional extra stall cycles. The stimulus also pulses start at most once while idle per run, plus one deliberate pulse during a busy run. Byte sequences are chosen so that the bits that should be ignored change independently of the bit under test.

// File: rtl/rp_pkg.sv
package rp_pkg;
    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_POLL = 1'b1
    } rp_state_e;

    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned POLL_BIT   = 7;
    localparam logic        MODE_TOGGLE = 1'b0;
    localparam logic        MODE_DATA   = 1'b1;
endpackage

// File: rtl/rp_bit_judge.sv
module rp_bit_judge
    import rp_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          mode,
    input  logic [DW-1:0] sample,
    input  logic          ref_bit,
    input  logic          expect_bit,
    output logic          hit
);
    always_comb begin
        if (mode == MODE_DATA) begin
            hit = (sample[POLL_BIT] == expect_bit);
        end else begin
            hit = (sample[TOGGLE_BIT] == ref_bit);
        end
    end
endmodule

// File: rtl/rp_try_counter.sv
module rp_try_counter #(
    parameter int unsigned LIMIT = 32'h0FFF_FFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (bump && (count_q != TOP)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign last = (count_q == TOP);

    // R8: the attempt count never passes the last legal value
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TOP);
endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
    import rp_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 32'h0FFF_FFFF,
    parameter int unsigned DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [DW-1:0] expect_i,
    output logic          rd_req_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          done_o,
    output logic          timeout_o
);
    typedef struct packed {
        rp_state_e state;
        logic      mode;
        logic      exp_bit;
        logic      ref_bit;
        logic      have_ref;
        logic      done;
        logic      tout;
    } rp_regs_t;

    rp_regs_t r_d, r_q;

    logic accept;
    logic hit;
    logic last_try;
    logic cnt_clear;
    logic cnt_bump;
    logic ref_only;

    rp_bit_judge #(.DW(DW)) u_judge (
        .mode       (r_q.mode),
        .sample     (rd_data_i),
        .ref_bit    (r_q.ref_bit),
        .expect_bit (r_q.exp_bit),
        .hit        (hit)
    );

    rp_try_counter #(.LIMIT(MAX_TRIES)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .bump  (cnt_bump),
        .last  (last_try)
    );

    assign accept    = (r_q.state == RP_POLL) && rd_valid_i;
    assign ref_only  = (r_q.mode == MODE_TOGGLE) && !r_q.have_ref;
    assign cnt_clear = (r_q.state == RP_IDLE) && start_i;
    assign cnt_bump  = accept && !ref_only && !hit;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tout = 1'b0;
        unique case (r_q.state)
            RP_IDLE: begin
                if (start_i) begin
                    r_d.state    = RP_POLL;
                    r_d.mode     = mode_i;
                    r_d.exp_bit  = expect_i[POLL_BIT];
                    r_d.have_ref = 1'b0;
                end
            end
            RP_POLL: begin
                if (accept) begin
                    if (ref_only) begin
                        r_d.ref_bit  = rd_data_i[TOGGLE_BIT];
                        r_d.have_ref = 1'b1;
                    end else if (hit) begin
                        r_d.done  = 1'b1;
                        r_d.state = RP_IDLE;
                    end else begin
                        r_d.ref_bit = rd_data_i[TOGGLE_BIT];
                        if (last_try) begin
                            r_d.tout  = 1'b1;
                            r_d.state = RP_IDLE;
                        end
                    end
                end
            end
            default: r_d.state = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: RP_IDLE, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o  = (r_q.state == RP_POLL);
    assign done_o    = r_q.done;
    assign timeout_o = r_q.tout;

    // R2: a start while idle opens a read request on the next cycle
    a_r2_start_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_o && start_i) |=> rd_req_o);

    // R3: the request is held until the bus port answers
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    // R9: outcome pulses are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    // R9: each outcome lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |=> !(done_o || timeout_o));

    // R9: an outcome follows an accepted read and the request is dropped
    a_r9_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> ($past(rd_req_o && rd_valid_i) && !rd_req_o));

    // R10: a start during a run does not change the captured settings
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && start_i && !rd_valid_i) |=> ($stable(r_q.mode) && $stable(r_q.exp_bit)));
endmodule

// File: tb/flash_ready_poller_test.sv
module flash_ready_poller_test;
    localparam int unsigned LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] expect_i = 8'h00;
    logic       rd_req_o;
    logic       rd_valid_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       done_o;
    logic       timeout_o;

    int tests = 0;
    int fails = 0;

    logic [7:0] seq [16];
    int  idx = 0;
    bit  slow = 1'b0;
    int  tick = 0;

    int  exp_kind  [$];
    int  exp_reads [$];
    string exp_tag [$];

    always #2.5 clk = ~clk;

    flash_ready_poller #(.MAX_TRIES(LIM)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .expect_i   (expect_i),
        .rd_req_o   (rd_req_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .done_o     (done_o),
        .timeout_o  (timeout_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // bus model: answers one read per request, then drops valid
    always @(negedge clk) begin
        tick++;
        if (rd_valid_i) begin
            rd_valid_i = 1'b0;
        end else if (rd_req_o && (!slow || (tick % 3 == 0))) begin
            rd_valid_i = 1'b1;
            rd_data_i  = seq[idx % 16];
            idx++;
        end
    end

    // monitor: pops expected outcomes as pulses appear
    always @(negedge clk) begin
        if (rst_n && (done_o || timeout_o)) begin
            if (exp_kind.size() == 0) begin
                check(1'b0, "R9 unexpected pulse", 1, 0);
            end else begin
                int k, n;
                string t;
                k = exp_kind.pop_front();
                n = exp_reads.pop_front();
                t = exp_tag.pop_front();
                check((timeout_o ? 1 : 0) == k, {t, " outcome kind"}, timeout_o ? 1 : 0, k);
                check(idx == n, {t, " reads used"}, idx, n);
                check(!(done_o && timeout_o) && !rd_req_o, "R9 pulse exclusive, req low",
                      int'(rd_req_o), 0);
            end
        end
    end

    function automatic void model(input bit mode, input logic [7:0] ex,
                                  output int kind, output int reads);
        int tries = 0;
        kind = 0;
        reads = 0;
        if (mode == 1'b0) begin
            logic r;
            r = seq[0][6];
            for (int i = 1; i < 16; i++) begin
                if (seq[i][6] == r) begin kind = 0; reads = i + 1; return; end
                r = seq[i][6];
                tries++;
                if (tries == LIM) begin kind = 1; reads = i + 1; return; end
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (seq[i][7] == ex[7]) begin kind = 0; reads = i + 1; return; end
                tries++;
                if (tries == LIM) begin kind = 1; reads = i + 1; return; end
            end
        end
    endfunction

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 16; i++) seq[i] = v;
    endtask

    task automatic run(input bit mode, input logic [7:0] ex, input string tag,
                       input bit busy_start);
        int k, n;
        model(mode, ex, k, n);
        exp_kind.push_back(k);
        exp_reads.push_back(n);
        exp_tag.push_back(tag);
        @(negedge clk);
        idx = 0;
        mode_i = mode;
        expect_i = ex;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(rd_req_o == 1'b1, "R2 request after start", int'(rd_req_o), 1);
        if (busy_start) begin
            wait (idx >= 1);
            @(negedge clk);
            mode_i = ~mode;
            expect_i = ~ex;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (exp_kind.size() == 0);
        repeat (2) @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o, {tag, " R9 back to idle"}, int'(rd_req_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o, "R1 reset outputs", int'(rd_req_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o, "R1 idle after reset", int'(done_o), 0);

        // R4 R5 R6: toggle, one flip then settle
        fill(8'h00); seq[0] = 8'h40; seq[1] = 8'h00; seq[2] = 8'h00;
        run(1'b0, 8'h00, "R6 toggle settle", 1'b0);
        // R4 R5: toggle settled at first compare
        fill(8'h40);
        run(1'b0, 8'h00, "R4 toggle immediate", 1'b0);
        // R5: other bits ignored
        fill(8'h00); seq[0] = 8'hBF; seq[1] = 8'h00;
        run(1'b0, 8'h00, "R5 toggle other bits", 1'b0);
        // R8: toggle timeout
        for (int i = 0; i < 16; i++) seq[i] = (i % 2) ? 8'h40 : 8'h00;
        run(1'b0, 8'h00, "R8 toggle timeout", 1'b0);
        // R7: data polling, match on third read
        fill(8'h80); seq[0] = 8'h00; seq[1] = 8'h7F;
        run(1'b1, 8'h80, "R7 data match", 1'b0);
        // R7: low bits ignored
        fill(8'h7F); seq[0] = 8'h80;
        run(1'b1, 8'h00, "R7 data low bits", 1'b0);
        // R7: immediate
        fill(8'hFF);
        run(1'b1, 8'hC3, "R7 data immediate", 1'b0);
        // R8: data timeout with stalled bus (R3)
        slow = 1'b1;
        fill(8'h00);
        run(1'b1, 8'h80, "R8 R3 data timeout slow", 1'b0);
        slow = 1'b0;
        // R10: start during run ignored
        fill(8'h80); seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h00;
        run(1'b1, 8'h80, "R10 busy start", 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule